// File: doc/BRIEF.md
# Microframe Interrupt Threshold Controller

This block sits between a USB controller core and the interrupt line it drives. Status events from the core arrive as single-cycle pulses and land in sticky status bits. Software clears those bits by writing 1. Each status bit has an enable, and only enabled, set bits can request an interrupt. A threshold code taken from the command register limits how often the interrupt line can rise. A code of zero passes requests through at once. A one-hot code sets a window that is a power of two microframes long, counted on a microframe tick, and the interrupt can only rise at the end of a window.

The block also holds the asynchronous-advance doorbell. Software rings it by writing 1 to the doorbell lane of the command register. When the core later pulses "advance done" while the doorbell is set, the block sets the advance status bit. In the next cycle it drops the doorbell by itself. Every pin is a plain control or status level. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `uframe_irq_throttle`

## Requirements
- R1: After reset every status bit is 0, the doorbell is 0, the irq output is 0, and the threshold readback is 0x08.
- R2: A command write (cmd_wr high) loads cmd_thr_wdata, which is command register bits 23:16, into the threshold readback on the next edge. The same write restarts the microframe count from zero.
- R3: With threshold code 0x00, or with any code outside the list 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, irq equals the OR of the enabled status bits as soon as the status bits update. No tick is needed.
- R4: With a listed one-hot code, the window length in microframes equals the code value (0x40 gives 64). An enabled status that is pending raises irq only on the edge of the tick that ends a window, which is the Nth tick after the last command write. Until then irq stays 0.
- R5: Status bit i sets on evt_pulse[i] and stays set. It clears only when sts_clr_wr is high with sts_clr_mask[i] = 1. A set and a clear in the same cycle leave the bit set. Mask bits that are 0 leave their bits unchanged.
- R6: A command write with cmd_ring_wdata = 1 sets the doorbell. A write with cmd_ring_wdata = 0 leaves the doorbell as it was.
- R7: The top status bit (index N_EVT) is the advance status. When adv_done pulses while the doorbell is 1, that bit sets on the next edge and the doorbell clears one edge later. When adv_done pulses with the doorbell at 0, nothing changes.
- R8: While device_mode is high, a ring write does not set the doorbell.
- R9: A set status bit whose irq_en bit is 0 never raises irq. In a windowed mode, irq falls one cycle after the last enabled status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| evt_pulse | input | N_EVT | Status event set pulses from the core |
| irq_en | input | N_EVT+1 | Per-status interrupt enables (top bit: advance status) |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_thr_wdata | input | 8 | Threshold field of the write (command bits 23:16) |
| cmd_ring_wdata | input | 1 | Doorbell lane of the write |
| sts_clr_wr | input | 1 | Status write strobe (write-one-to-clear) |
| sts_clr_mask | input | N_EVT+1 | Bits to clear on a status write |
| device_mode | input | 1 | Controller is in device mode |
| adv_done | input | 1 | Core has finished the asynchronous advance |
| irq | output | 1 | Interrupt request |
| sts | output | N_EVT+1 | Sticky status bits |
| thr_code | output | 8 | Threshold code readback |
| doorbell | output | 1 | Doorbell readback |

## Verification
The hardest case to reach is the window edge itself: a pending enabled status must stay silent through N-1 ticks and appear on exactly the Nth one. This is hard to see because the window phase is invisible at the ports. The bench pins the phase down by issuing a command write, which restarts the count, and then counting ticks it drives one at a time. It does this for windows of 1, 4 and 64, and once more after a write in the middle of a window. The two-step doorbell handshake is observed edge by edge: first the status bit rises while the doorbell is still set, and one cycle later the doorbell falls.

// File: rtl/uit_pkg.sv
package uit_pkg;
  localparam int          THR_W     = 8;
  localparam int          MAX_SHIFT = 6;
  localparam logic [7:0]  THR_RESET = 8'h08;
endpackage

// File: rtl/uit_thresh_timer.sv
module uit_thresh_timer
  import uit_pkg::*;
#(
  parameter int TW    = THR_W,
  parameter int SHIFT = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_code,
  input  logic          tick,
  output logic [TW-1:0] code_q,
  output logic          immediate,
  output logic          boundary
);
  localparam int CNT_W = (SHIFT < 1) ? 1 : SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             listed;

  always_comb begin
    listed = 1'b0;
    lim    = '0;
    for (int k = 0; k <= SHIFT; k++) begin
      if (code_q == (TW'(1) << k)) begin
        listed = 1'b1;
        lim    = CNT_W'((32'd1 << k) - 32'd1);
      end
    end
  end

  assign immediate = !listed;
  assign boundary  = tick && listed && !load && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= TW'(THR_RESET);
      cnt_q  <= '0;
    end else if (load) begin
      code_q <= load_code;
      cnt_q  <= '0;
    end else if (tick && listed) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));

  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    listed |-> (cnt_q <= lim));
endmodule

// File: rtl/uit_status_bank.sv
module uit_status_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] sts_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sts_q[i] <= 1'b0;
      else if (set_i[i])              sts_q[i] <= 1'b1;
      else if (clr_wr && clr_mask[i]) sts_q[i] <= 1'b0;
    end

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(clr_wr && clr_mask[i])) |=> sts_q[i]);
  end
endmodule

// File: rtl/uit_doorbell.sv
module uit_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_wr,
  input  logic device_mode,
  input  logic adv_done,
  output logic db_q,
  output logic adv_set
);
  logic clr_pend_q;

  assign adv_set = adv_done && db_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q       <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      clr_pend_q <= adv_set;
      if (ring_wr && !device_mode) db_q <= 1'b1;
      else if (clr_pend_q)         db_q <= 1'b0;
    end
  end

  assert_dev_ignores_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_wr && device_mode && !db_q) |=> !db_q);
endmodule

// File: rtl/uframe_irq_throttle.sv
module uframe_irq_throttle
  import uit_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int N_STS = N_EVT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uframe_tick,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_STS-1:0] irq_en,
  input  logic             cmd_wr,
  input  logic [THR_W-1:0] cmd_thr_wdata,
  input  logic             cmd_ring_wdata,
  input  logic             sts_clr_wr,
  input  logic [N_STS-1:0] sts_clr_mask,
  input  logic             device_mode,
  input  logic             adv_done,
  output logic             irq,
  output logic [N_STS-1:0] sts,
  output logic [THR_W-1:0] thr_code,
  output logic             doorbell
);
  logic immediate, boundary, adv_set, any_req, irq_q;

  uit_thresh_timer #(.TW(THR_W), .SHIFT(MAX_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(cmd_wr), .load_code(cmd_thr_wdata),
    .tick(uframe_tick), .code_q(thr_code), .immediate(immediate),
    .boundary(boundary)
  );

  uit_doorbell u_db (
    .clk(clk), .rst_n(rst_n), .ring_wr(cmd_wr && cmd_ring_wdata),
    .device_mode(device_mode), .adv_done(adv_done), .db_q(doorbell),
    .adv_set(adv_set)
  );

  uit_status_bank #(.N(N_STS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i({adv_set, evt_pulse}),
    .clr_wr(sts_clr_wr), .clr_mask(sts_clr_mask), .sts_q(sts)
  );

  assign any_req = |(sts & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (!any_req) irq_q <= 1'b0;
    else if (boundary) irq_q <= 1'b1;
  end

  assign irq = immediate ? any_req : irq_q;

  assert_irq_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(boundary));

  assert_adv_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_done && doorbell) |=> sts[N_STS-1]);

  assert_db_falls_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> $past(sts[N_STS-1]));
endmodule

// File: tb/uframe_irq_throttle_bench.sv
module uframe_irq_throttle_bench;
  localparam int N_EVT = 4;
  localparam int N_STS = N_EVT + 1;
  localparam int ADV   = N_EVT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uframe_tick = 1'b0;
  logic [N_EVT-1:0] evt_pulse = '0;
  logic [N_STS-1:0] irq_en = '0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_thr_wdata = '0;
  logic cmd_ring_wdata = 1'b0;
  logic sts_clr_wr = 1'b0;
  logic [N_STS-1:0] sts_clr_mask = '0;
  logic device_mode = 1'b0;
  logic adv_done = 1'b0;
  logic irq, doorbell;
  logic [N_STS-1:0] sts;
  logic [7:0] thr_code;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uframe_irq_throttle #(.N_EVT(N_EVT)) u_uframe_irq_throttle (
    .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .evt_pulse(evt_pulse),
    .irq_en(irq_en), .cmd_wr(cmd_wr), .cmd_thr_wdata(cmd_thr_wdata),
    .cmd_ring_wdata(cmd_ring_wdata), .sts_clr_wr(sts_clr_wr),
    .sts_clr_mask(sts_clr_mask), .device_mode(device_mode), .adv_done(adv_done),
    .irq(irq), .sts(sts), .thr_code(thr_code), .doorbell(doorbell)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_cmd(logic [7:0] code, logic ring);
    @(negedge clk); cmd_wr = 1'b1; cmd_thr_wdata = code; cmd_ring_wdata = ring;
    @(negedge clk); cmd_wr = 1'b0; cmd_ring_wdata = 1'b0;
  endtask

  task automatic pulse_evt(logic [N_EVT-1:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic clr_sts(logic [N_STS-1:0] m);
    @(negedge clk); sts_clr_wr = 1'b1; sts_clr_mask = m;
    @(negedge clk); sts_clr_wr = 1'b0; sts_clr_mask = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); uframe_tick = 1'b1;
      @(negedge clk); uframe_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1", "status", int'(sts), 0);
    chk("R1", "doorbell", int'(doorbell), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "thr_code", int'(thr_code), 8'h08);
  endtask

  task automatic t_immediate;
    irq_en = 5'b0_1011;
    wr_cmd(8'h00, 1'b0);
    chk("R2", "thr_code after write", int'(thr_code), 0);
    pulse_evt(4'b0010);
    chk("R3", "status set", int'(sts), 5'b00010);
    chk("R3", "irq immediate", int'(irq), 1);
    clr_sts(5'b00010);
    chk("R5", "w1c clears", int'(sts), 0);
    chk("R3", "irq drops", int'(irq), 0);
    pulse_evt(4'b0100);
    chk("R9", "disabled status set", int'(sts), 5'b00100);
    chk("R9", "disabled no irq", int'(irq), 0);
    clr_sts(5'b00100);
  endtask

  task automatic t_unlisted(logic [7:0] code);
    wr_cmd(code, 1'b0);
    chk("R2", "thr_code readback", int'(thr_code), int'(code));
    pulse_evt(4'b0001);
    chk("R3", "unlisted code immediate irq", int'(irq), 1);
    clr_sts(5'b00001);
    chk("R3", "unlisted irq drops", int'(irq), 0);
  endtask

  task automatic t_window(logic [7:0] code);
    int n = int'(code);
    wr_cmd(code, 1'b0);
    pulse_evt(4'b0001);
    ticks(n - 1);
    chk("R4", $sformatf("no irq before tick %0d", n), int'(irq), 0);
    ticks(1);
    chk("R4", $sformatf("irq at tick %0d", n), int'(irq), 1);
    clr_sts(5'b00001);
    @(negedge clk);
    chk("R9", "windowed irq falls after clear", int'(irq), 0);
  endtask

  task automatic t_restart;
    wr_cmd(8'h04, 1'b0);
    ticks(3);
    wr_cmd(8'h04, 1'b0);
    pulse_evt(4'b0001);
    ticks(3);
    chk("R2", "restart delays boundary", int'(irq), 0);
    ticks(1);
    chk("R2", "boundary after restart", int'(irq), 1);
    clr_sts(5'b00001);
    @(negedge clk);
  endtask

  task automatic t_set_wins;
    pulse_evt(4'b1000);
    @(negedge clk); evt_pulse = 4'b1000; sts_clr_wr = 1'b1; sts_clr_mask = 5'b01000;
    @(negedge clk); evt_pulse = '0; sts_clr_wr = 1'b0; sts_clr_mask = '0;
    chk("R5", "set beats clear", int'(sts), 5'b01000);
    pulse_evt(4'b0001);
    clr_sts(5'b00001);
    chk("R5", "masked clear keeps others", int'(sts), 5'b01000);
    clr_sts(5'b01000);
  endtask

  task automatic t_doorbell;
    irq_en = 5'b1_0000;
    wr_cmd(8'h00, 1'b1);
    chk("R6", "ring sets doorbell", int'(doorbell), 1);
    wr_cmd(8'h00, 1'b0);
    chk("R6", "write 0 keeps doorbell", int'(doorbell), 1);
    @(negedge clk); adv_done = 1'b1;
    @(negedge clk); adv_done = 1'b0;
    chk("R7", "advance status set", int'(sts[ADV]), 1);
    chk("R7", "doorbell still set", int'(doorbell), 1);
    @(negedge clk);
    chk("R7", "doorbell cleared", int'(doorbell), 0);
    chk("R7", "advance irq", int'(irq), 1);
    clr_sts(5'b10000);
    @(negedge clk); adv_done = 1'b1;
    @(negedge clk); adv_done = 1'b0;
    chk("R7", "advance ignored without doorbell", int'(sts[ADV]), 0);
    wr_cmd(8'h02, 1'b1);
    @(negedge clk); adv_done = 1'b1;
    @(negedge clk); adv_done = 1'b0;
    ticks(1);
    chk("R7", "advance irq waits for boundary", int'(irq), 0);
    ticks(1);
    chk("R7", "advance irq at boundary", int'(irq), 1);
    clr_sts(5'b10000);
    @(negedge clk);
  endtask

  task automatic t_device;
    device_mode = 1'b1;
    wr_cmd(8'h00, 1'b1);
    chk("R8", "device mode ignores ring", int'(doorbell), 0);
    device_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_unlisted(8'h03);
    t_unlisted(8'h80);
    irq_en = 5'b0_0001;
    t_window(8'h01);
    t_window(8'h04);
    t_window(8'h40);
    t_restart();
    t_set_wins();
    t_doorbell();
    t_device();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule